// File: doc/BRIEF.md
# Ethernet destination address filter

This block watches the bytes of a received Ethernet frame as they arrive and decides, from the 48-bit destination address at the head of the frame, whether the frame should be kept. It holds a bank of programmable exact-match address slots, a per-slot enable mask and a mode word. All of them are reachable through a simple 32-bit register port with write strobe and combinational readback. The mode word can admit whole address classes (unicast, multicast, broadcast). It can also switch the slot comparison on and invert its sense, so that the bank works as a block list rather than an allow list.

The byte stream carries a valid strobe, a start-of-frame marker on the first byte and an end marker on the last byte. Gaps between bytes are allowed. One cycle after the sixth byte the block pulses a decision: accept or reject, whether any enabled slot matched, and the lowest index among the matching slots. Frames shorter than six bytes are rejected. The configuration is captured at the first byte of each frame, so register writes made while a frame is in progress only take effect for the next frame. Checksum checking, buffering and DMA belong to other blocks.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset the mode word, the enable mask and every slot read as zero, and every complete frame is rejected.
- R2: Register map, using word-aligned addresses only:
  - 0x00 is the mode word; bits 4:0 are stored and higher bits read as zero.
  - 0x04 is the enable mask; bit i enables slot i, and bits 31:16 read as zero.
  - Slot i has an upper word at 0x08+8i, holding address bytes 0..3 with byte 0 in bits 31:24.
  - Slot i has a lower word at 0x0C+8i, holding byte 4 in bits 31:24 and byte 5 in bits 23:16; bits 15:0 of the lower word are ignored on write and read as zero.
  - Unmapped addresses read as zero.
- R3: A slot matches when it is enabled and all six destination bytes equal its stored bytes. A disabled slot never matches. With mode bit 4 set and bit 3 clear, a match accepts the frame.
- R4: With mode bits 4 and 3 both set, the comparison is true only when no enabled slot matches. The hit output always reports the raw match, before this inversion.
- R5: Address classes. Broadcast is all 48 bits set. Multicast is bit 0 of byte 0 set but not broadcast. Everything else is unicast. Mode bit 0 accepts any unicast frame, bit 1 any multicast frame and bit 2 broadcast, independent of the slots.
- R6: With mode bits 0, 1 and 2 set (0x17 being the promiscuous setting), every frame is accepted.
- R7: dec_valid is high for exactly one cycle, starting one cycle after the sixth byte is taken. dec_hit and dec_accept are low whenever dec_valid is low. On a hit, dec_index is the lowest matching enabled slot.
- R8: A frame whose end marker arrives on byte 1 to 5 produces dec_valid with dec_accept low, one cycle after that byte. Bytes after the sixth produce no further decision.
- R9: Writes to any register while a frame is in progress do not affect that frame's decision; they apply from the next start-of-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational readback of reg_addr |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_hit | output | 1 | An enabled slot matched |
| dec_index | output | IDX_W | Lowest matching slot |

## Verification
The decision outputs are registered at the clock edge that takes the sixth byte, or the short frame's end byte. The bench therefore drives each byte on a falling edge and reads the decision on the falling edge right after the last byte's rising edge. It reads again one cycle later to confirm the pulse has gone. Readback is combinational, so it is sampled one time unit after the address changes on a falling edge. A register write lands on the rising edge after the strobe, and no frame is started before that edge. Mid-frame writes are placed in a gap between bytes 3 and 4, and the expected decision is computed from the configuration held before the write.

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W = 8,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_data,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic              dec_hit,
  output logic [IDX_W-1:0]  dec_index
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic aligned;
  assign word = reg_addr[ADDR_W-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);

  logic [4:0] cfg_mode, act_mode;
  logic [NUM_ENTRIES-1:0] cfg_en, act_en;
  logic [47:0] cfg_addr [NUM_ENTRIES];
  logic [47:0] act_addr [NUM_ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_mode <= '0;
      cfg_en <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) cfg_addr[i] <= '0;
    end else if (reg_wr && aligned) begin
      if (word == WORD_W'(0)) cfg_mode <= reg_wdata[4:0];
      if (word == WORD_W'(1)) cfg_en <= reg_wdata[NUM_ENTRIES-1:0];
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (int'(word) == 2*i+2) cfg_addr[i][47:16] <= reg_wdata;
        if (int'(word) == 2*i+3) cfg_addr[i][15:0] <= reg_wdata[31:16];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      if (word == WORD_W'(0)) reg_rdata = {27'd0, cfg_mode};
      if (word == WORD_W'(1)) reg_rdata = 32'(cfg_en);
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (int'(word) == 2*i+2) reg_rdata = cfg_addr[i][47:16];
        if (int'(word) == 2*i+3) reg_rdata = {cfg_addr[i][15:0], 16'd0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_mode <= '0;
      act_en <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) act_addr[i] <= '0;
    end else if (in_valid && in_sof) begin
      act_mode <= cfg_mode;
      act_en <= cfg_en;
      for (int i = 0; i < NUM_ENTRIES; i++) act_addr[i] <= cfg_addr[i];
    end
  end

  function automatic logic [7:0] get_byte(input logic [47:0] a, input logic [2:0] k);
    case (k)
      3'd0: get_byte = a[47:40];
      3'd1: get_byte = a[39:32];
      3'd2: get_byte = a[31:24];
      3'd3: get_byte = a[23:16];
      3'd4: get_byte = a[15:8];
      default: get_byte = a[7:0];
    endcase
  endfunction

  logic [2:0] cnt, pos;
  logic in_frame, take, last, short_end;
  logic [NUM_ENTRIES-1:0] mvec, mvec_nxt, hitv;
  logic bc, mc, bc_nxt, mc_nxt, any_hit, cmp_ok, is_uc, is_mc, acc_nxt;
  logic [IDX_W-1:0] low_idx;

  assign take = in_valid && (in_sof || in_frame);
  assign pos = in_sof ? 3'd0 : cnt;
  assign last = take && (pos == 3'd5);
  assign short_end = take && in_eof && (pos < 3'd5);

  always_comb begin
    logic [47:0] ent;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      ent = in_sof ? cfg_addr[i] : act_addr[i];
      mvec_nxt[i] = ((pos == 3'd0) || mvec[i]) && (get_byte(ent, pos) == in_data);
    end
  end

  assign bc_nxt = ((pos == 3'd0) || bc) && (in_data == 8'hFF);
  assign mc_nxt = (pos == 3'd0) ? in_data[0] : mc;
  assign hitv = mvec_nxt & act_en;
  assign any_hit = |hitv;
  assign cmp_ok = act_mode[3] ? !any_hit : any_hit;
  assign is_mc = mc_nxt && !bc_nxt;
  assign is_uc = !mc_nxt && !bc_nxt;
  assign acc_nxt = (act_mode[4] && cmp_ok) || (is_uc && act_mode[0]) ||
                   (is_mc && act_mode[1]) || (bc_nxt && act_mode[2]);

  always_comb begin
    low_idx = '0;
    for (int i = NUM_ENTRIES-1; i >= 0; i--)
      if (hitv[i]) low_idx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      in_frame <= 1'b0;
      mvec <= '0;
      bc <= 1'b0;
      mc <= 1'b0;
      dec_valid <= 1'b0;
      dec_accept <= 1'b0;
      dec_hit <= 1'b0;
      dec_index <= '0;
    end else begin
      if (take) begin
        mvec <= mvec_nxt;
        bc <= bc_nxt;
        mc <= mc_nxt;
        cnt <= pos + 3'd1;
        in_frame <= !(pos == 3'd5 || in_eof);
      end
      dec_valid <= last || short_end;
      dec_accept <= last && acc_nxt;
      dec_hit <= last && any_hit;
      dec_index <= last ? low_idx : '0;
    end
  end

  p_reset_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && act_mode == 5'd0) |-> !dec_accept);

  if (NUM_ENTRIES < 32) begin : g_en_rd
    p_en_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(4)) |-> (reg_rdata[31:NUM_ENTRIES] == '0));
  end

  p_hit_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_hit) |-> act_en[dec_index]);

  p_promisc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_frame && !in_sof && cnt == 3'd5 && act_mode[2:0] == 3'b111) |=> dec_accept);

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_accept && !dec_hit));

  p_short_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof && (in_sof || (in_frame && cnt < 3'd5))) |=> (dec_valid && !dec_accept));

  p_frame_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !(in_valid && in_sof)) |=> ($stable(act_mode) && $stable(act_en)));
endmodule

// File: tb/sim_dest_addr_filter.sv
module sim_dest_addr_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic dec_valid, dec_accept, dec_hit;
  logic [3:0] dec_index;

  always #2.5 clk = ~clk;

  dest_addr_filter #(.NUM_ENTRIES(16), .ADDR_W(8)) u0 (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .in_valid, .in_sof, .in_eof, .in_data,
    .dec_valid, .dec_accept, .dec_hit, .dec_index);

  int n_chk = 0, n_fail = 0;
  logic [4:0] m_mode = '0;
  logic [15:0] m_en = '0;
  logic [47:0] m_ent [16];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_mode(input logic [31:0] d); wr(8'h00, d); m_mode = d[4:0]; endtask
  task automatic set_en(input logic [31:0] d); wr(8'h04, d); m_en = d[15:0]; endtask
  task automatic set_ent(input int i, input logic [47:0] a);
    wr(8'(8 + 8*i), a[47:16]);
    wr(8'(12 + 8*i), {a[15:0], 16'($urandom)});
    m_ent[i] = a;
  endtask

  task automatic rdchk(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
  endtask

  function automatic void model(input logic [47:0] da, output bit acc, output bit hit, output int idx);
    bit bcast, mcast, ucast, cmp;
    hit = 0; idx = 0;
    for (int i = 15; i >= 0; i--)
      if (m_en[i] && m_ent[i] == da) begin hit = 1; idx = i; end
    bcast = &da;
    mcast = da[40] && !bcast;
    ucast = !bcast && !mcast;
    cmp = m_mode[3] ? !hit : hit;
    acc = (m_mode[4] && cmp) || (ucast && m_mode[0]) || (mcast && m_mode[1]) || (bcast && m_mode[2]);
  endfunction

  function automatic logic [7:0] byte_of(input logic [47:0] da, input int k);
    return (k < 6) ? da[47-8*k -: 8] : 8'hA5;
  endfunction

  task automatic send_part(input logic [47:0] da, input int lo, input int hi, input bit eof_last);
    for (int k = lo; k <= hi; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (k == 0); in_eof = eof_last && (k == hi);
      in_data = byte_of(da, k);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic check_dec(input bit acc, input bit hit, input int idx, input string req);
    chk(dec_valid == 1'b1, {req, " valid"}, 64'(dec_valid), 64'd1);
    chk(dec_accept == acc, {req, " accept"}, 64'(dec_accept), 64'(acc));
    chk(dec_hit == hit, {req, " hit"}, 64'(dec_hit), 64'(hit));
    if (hit) chk(int'(dec_index) == idx, {req, " index"}, 64'(dec_index), 64'(idx));
    @(negedge clk);
    chk(dec_valid == 1'b0, {req, " single pulse R7"}, 64'(dec_valid), 64'd0);
  endtask

  task automatic frame(input logic [47:0] da, input string req);
    bit acc, hit; int idx;
    model(da, acc, hit, idx);
    send_part(da, 0, 5, 1'b1);
    check_dec(acc, hit, idx, req);
  endtask

  localparam logic [47:0] X = 48'h02_11_22_33_44_55;
  localparam logic [47:0] Y = 48'h04_66_77_88_99_AA;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC = 48'h01_00_5E_00_00_01;

  initial begin
    bit acc, hit; int idx;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) m_ent[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rdchk(8'h00, 32'h0, "R1 mode");
    rdchk(8'h04, 32'h0, "R1 enable");
    rdchk(8'h08, 32'h0, "R1 slot0 upper");
    rdchk(8'h84, 32'h0, "R1 slot15 lower");
    frame(BC, "R1 bcast after reset");
    frame(X, "R1 unicast after reset");

    // R2: register map
    set_mode(32'hFFFF_FFFF);
    rdchk(8'h00, 32'h1F, "R2 mode width");
    set_en(32'hFFFF_FFFF);
    rdchk(8'h04, 32'h0000_FFFF, "R2 enable upper zero");
    wr(8'h20, 32'hDEAD_BEEF);
    wr(8'h24, 32'hAABB_CCDD);
    m_ent[3] = 48'hDEAD_BEEF_AABB;
    rdchk(8'h20, 32'hDEAD_BEEF, "R2 slot3 upper");
    rdchk(8'h24, 32'hAABB_0000, "R2 slot3 lower");
    rdchk(8'h22, 32'h0, "R2 unaligned");
    rdchk(8'hFC, 32'h0, "R2 unmapped");
    set_ent(3, 48'h0);
    set_en(32'h0);

    // R3: exact match, enable gate
    set_ent(5, X);
    set_en(32'h20);
    set_mode(32'h10);
    frame(X, "R3 match slot5");
    frame(Y, "R3 no match");
    frame(X ^ 48'h1, "R3 last byte differs");
    set_en(32'h0);
    frame(X, "R3 disabled slot");

    // R7: lowest index wins
    set_ent(2, Y); set_ent(9, Y);
    set_en(32'h0224);
    frame(Y, "R7 lowest index");

    // R4: complement
    set_mode(32'h18);
    frame(X, "R4 complement listed");
    frame(48'h02_00_00_00_00_07, "R4 complement unlisted");

    // R5: class flags
    set_en(32'h0);
    set_mode(32'h04);
    frame(BC, "R5 bcast flag");
    frame(MC, "R5 mcast under bcast flag");
    set_mode(32'h02);
    frame(MC, "R5 mcast flag");
    frame(BC, "R5 bcast under mcast flag");
    set_mode(32'h01);
    frame(X, "R5 unicast flag");
    frame(MC, "R5 mcast under unicast flag");

    // R6: promiscuous
    set_mode(32'h17);
    for (int n = 0; n < 8; n++) frame({$urandom, 16'($urandom)}, "R6 promiscuous");

    // R8: short frames and trailing bytes
    send_part(BC, 0, 2, 1'b1);
    check_dec(1'b0, 1'b0, 0, "R8 short 3 bytes");
    send_part(BC, 0, 0, 1'b1);
    check_dec(1'b0, 1'b0, 0, "R8 short 1 byte");
    model(X, acc, hit, idx);
    send_part(X, 0, 5, 1'b0);
    check_dec(acc, hit, idx, "R8 long frame decision");
    send_part(X, 6, 9, 1'b1);
    chk(dec_valid == 1'b0, "R8 trailing bytes", 64'(dec_valid), 64'd0);

    // R9: writes mid-frame
    set_mode(32'h10);
    set_en(32'h20);
    model(X, acc, hit, idx);
    send_part(X, 0, 2, 1'b0);
    chk(dec_valid == 1'b0, "R7 no early decision", 64'(dec_valid), 64'd0);
    set_en(32'h0);
    set_ent(5, Y);
    send_part(X, 3, 5, 1'b1);
    check_dec(acc, hit, idx, "R9 old config holds");
    set_en(32'h20);
    frame(X, "R9 old address gone");
    frame(Y, "R9 new address used");

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [47:0] da;
      int pick;
      if (n % 25 == 0) begin
        for (int i = 0; i < 16; i++) set_ent(i, {$urandom, 16'($urandom)});
        set_ent(7, m_ent[3]);
        set_en($urandom);
        set_mode($urandom);
      end
      pick = int'($urandom % 10);
      if (pick < 5) da = m_ent[$urandom % 16];
      else if (pick == 5) da = BC;
      else da = {$urandom, 16'($urandom)};
      frame(da, "R3 R4 R5 R7 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule